// File: doc/BRIEF.md
# Packed Colour Lookup Table

This block holds a 256-entry colour lookup table that a processor fills with 32-bit words. Each word holds two 16-bit colours with 5 bits per channel. When a word is written, both halves are widened to 8 bits per channel and stored as two neighbouring table entries. The original word is also kept so that software can read back exactly what it wrote.

A display pipeline presents an 8-bit pixel index on a separate lookup port. The 24-bit colour comes back on the following cycle, together with a valid strobe. The lookup port and the processor port work at the same time. Output pixel-depth conversion belongs to a later stage.

Top module: `pal_lut`

## Requirements
- R1: After reset, every processor read returns zero, every lookup returns zero, and `lk_valid` and `cpu_rdata` are low.
- R2: A write of `cpu_wdata` to word `cpu_waddr` is stored as is. A read with `cpu_re` high returns that word on `cpu_rdata` after the next clock edge, including the top bit of each half.
- R3: Word n fills table entry 2n from its bits [15:0] and entry 2n+1 from its bits [31:16].
- R4: In each 16-bit half, red is in bits [4:0], green in [9:5] and blue in [14:10]. `lk_rgb` carries red in [23:16], green in [15:8] and blue in [7:0].
- R5: Each 5-bit channel becomes 8 bits by a left shift of three with zeros below.
- R6: Bit 15 of each half (the intensity bit) has no effect on the looked-up colour.
- R7: A request with `lk_req` high at a clock edge gives `lk_valid` high with the colour after that edge. `lk_valid` is low after any edge without a request.
- R8: A lookup of an entry in the same cycle as a write to its word returns the old colour. The next lookup returns the new colour.
- R9: A processor read of a word in the same cycle as a write to that word returns the old word.
- R10: `lk_rgb` holds its last value while no lookup is requested, even if the table is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_we | input | 1 | Word write strobe |
| cpu_waddr | input | 7 | Word write address |
| cpu_wdata | input | 32 | Packed pair of colours |
| cpu_re | input | 1 | Word read strobe |
| cpu_raddr | input | 7 | Word read address |
| cpu_rdata | output | 32 | Raw word read back, registered |
| lk_req | input | 1 | Lookup request |
| lk_index | input | 8 | Pixel index to look up |
| lk_valid | output | 1 | Lookup result valid |
| lk_rgb | output | 24 | Looked-up colour, 8 bits per channel |

## Verification
The assertions check on every cycle that the lookup strobe tracks a request with one cycle of delay, that the colour output holds while idle, and that each write puts both widened colours into the correct pair of entries. They also check that a colliding lookup returns the pre-write entry and that output colours have zero low bits. Only the bench scenarios can show the bit layout of each channel, that the intensity bit is dropped, that the raw word reads back intact, the old-word result on a read/write collision, and the all-zero state after reset. These depend on known data patterns, not on relations between signals.

// File: rtl/pal_lut_pkg.sv
package pal_lut_pkg;
   localparam int CHAN_IN_W  = 5;
   localparam int CHAN_OUT_W = 8;
   localparam int NUM_CHAN   = 3;
   localparam int HALF_W     = 16;
   localparam int PAD_W      = CHAN_OUT_W - CHAN_IN_W;

   typedef logic [CHAN_OUT_W-1:0] chan_t;

   typedef struct packed {
      chan_t red;
      chan_t green;
      chan_t blue;
   } rgb_t;

   localparam int RGB_W = $bits(rgb_t);
endpackage

// File: rtl/pal_unpack.sv
module pal_unpack
   import pal_lut_pkg::*;
#(
   parameter bit ZERO_FILL = 1'b1
) (
   input  logic [HALF_W-1:0] half_in,
   output rgb_t              color_out
);
   chan_t wide [NUM_CHAN];

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      logic [CHAN_IN_W-1:0] field;
      assign field = half_in[c*CHAN_IN_W +: CHAN_IN_W];
      if (ZERO_FILL) begin : g_zero
         assign wide[c] = {field, {PAD_W{1'b0}}};
      end else begin : g_repl
         assign wide[c] = {field, field[CHAN_IN_W-1 -: PAD_W]};
      end
   end

   // the top bit of the half takes no part in the colour
   assign color_out = '{red: wide[0], green: wide[1], blue: wide[2]};
endmodule

// File: rtl/pal_raw_store.sv
module pal_raw_store #(
   parameter int DEPTH  = 128,
   parameter int WORD_W = 32,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end

   AST_RD_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> $stable(rdata)); // R2
   AST_RD_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      (we && re && waddr == raddr) |=> rdata != $past(wdata) || $past(wdata) == $past(mem[raddr])); // R9
endmodule

// File: rtl/pal_entry_store.sv
module pal_entry_store
   import pal_lut_pkg::*;
#(
   parameter int ENTRIES = 256,
   localparam int IW     = $clog2(ENTRIES),
   localparam int PW     = IW - 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [PW-1:0] wpair,
   input  rgb_t          lo_color,
   input  rgb_t          hi_color,
   input  logic          lk_req,
   input  logic [IW-1:0] lk_idx,
   output logic          lk_valid,
   output rgb_t          lk_rgb
);
   rgb_t mem [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
      end else if (we) begin
         mem[{wpair, 1'b0}] <= lo_color;
         mem[{wpair, 1'b1}] <= hi_color;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_valid <= 1'b0;
         lk_rgb   <= '0;
      end else begin
         lk_valid <= lk_req;
         if (lk_req) lk_rgb <= mem[lk_idx];
      end
   end

   AST_LK_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> lk_valid); // R7
   AST_LK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> !lk_valid); // R7
   AST_LK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> $stable(lk_rgb)); // R10
   AST_PAIR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[{$past(wpair), 1'b0}] == $past(lo_color)); // R3
   AST_PAIR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[{$past(wpair), 1'b1}] == $past(hi_color)); // R3
   AST_COLLIDE_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && we && lk_idx[IW-1:1] == wpair) |=> lk_rgb == $past(mem[lk_idx])); // R8
endmodule

// File: rtl/pal_lut.sv
module pal_lut
   import pal_lut_pkg::*;
#(
   parameter int RAW_DEPTH = 128,
   parameter int WORD_W    = 32,
   parameter bit ZERO_FILL = 1'b1,
   localparam int AW       = $clog2(RAW_DEPTH),
   localparam int ENTRIES  = 2 * RAW_DEPTH,
   localparam int IW       = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_we,
   input  logic [AW-1:0]     cpu_waddr,
   input  logic [WORD_W-1:0] cpu_wdata,
   input  logic              cpu_re,
   input  logic [AW-1:0]     cpu_raddr,
   output logic [WORD_W-1:0] cpu_rdata,
   input  logic              lk_req,
   input  logic [IW-1:0]     lk_index,
   output logic              lk_valid,
   output logic [RGB_W-1:0]  lk_rgb
);
   initial begin
      assert (WORD_W == 2 * HALF_W)
         else $error("word must hold exactly two colours");
      assert (RAW_DEPTH >= 2 && (1 << AW) == RAW_DEPTH)
         else $error("word count must be a power of two");
   end

   rgb_t half_color [2];
   rgb_t lk_color;

   pal_raw_store #(
      .DEPTH (RAW_DEPTH),
      .WORD_W(WORD_W)
   ) u_raw (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (cpu_we),
      .waddr(cpu_waddr),
      .wdata(cpu_wdata),
      .re   (cpu_re),
      .raddr(cpu_raddr),
      .rdata(cpu_rdata)
   );

   for (genvar h = 0; h < 2; h++) begin : g_half
      pal_unpack #(.ZERO_FILL(ZERO_FILL)) u_unpack (
         .half_in  (cpu_wdata[h*HALF_W +: HALF_W]),
         .color_out(half_color[h])
      );
   end

   pal_entry_store #(.ENTRIES(ENTRIES)) u_entries (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cpu_we),
      .wpair   (cpu_waddr),
      .lo_color(half_color[0]),
      .hi_color(half_color[1]),
      .lk_req  (lk_req),
      .lk_idx  (lk_index),
      .lk_valid(lk_valid),
      .lk_rgb  (lk_color)
   );

   assign lk_rgb = lk_color;

   if (ZERO_FILL) begin : g_fill_chk
      AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         lk_valid |-> (lk_color.red[PAD_W-1:0] == '0 && lk_color.green[PAD_W-1:0] == '0
                       && lk_color.blue[PAD_W-1:0] == '0)); // R5
   end
endmodule

// File: tb/test_pal_lut.sv
`timescale 1ns/1ps
module test_pal_lut;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_we = 1'b0;
   logic [6:0]  cpu_waddr = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_re = 1'b0;
   logic [6:0]  cpu_raddr = '0;
   logic [31:0] cpu_rdata;
   logic        lk_req = 1'b0;
   logic [7:0]  lk_index = '0;
   logic        lk_valid;
   logic [23:0] lk_rgb;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [31:0] shadow [128];

   always #2 clk = ~clk;

   pal_lut i_pal_lut (
      .clk(clk), .rst_n(rst_n),
      .cpu_we(cpu_we), .cpu_waddr(cpu_waddr), .cpu_wdata(cpu_wdata),
      .cpu_re(cpu_re), .cpu_raddr(cpu_raddr), .cpu_rdata(cpu_rdata),
      .lk_req(lk_req), .lk_index(lk_index), .lk_valid(lk_valid), .lk_rgb(lk_rgb)
   );

   function automatic logic [23:0] widen(input logic [15:0] h);
      return {h[4:0], 3'b000, h[9:5], 3'b000, h[14:10], 3'b000};
   endfunction

   function automatic logic [23:0] expect_entry(input int idx);
      logic [31:0] w;
      w = shadow[idx >> 1];
      return (idx % 2 == 1) ? widen(w[31:16]) : widen(w[15:0]);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(input int n, input logic [31:0] w);
      @(negedge clk);
      cpu_we = 1'b1; cpu_waddr = n[6:0]; cpu_wdata = w;
      @(negedge clk);
      cpu_we = 1'b0;
      shadow[n] = w;
   endtask

   task automatic do_read(input int n, input string tag);
      @(negedge clk);
      cpu_re = 1'b1; cpu_raddr = n[6:0];
      @(negedge clk);
      cpu_re = 1'b0;
      chk(tag, cpu_rdata, shadow[n]);
   endtask

   task automatic do_lookup(input int idx, input string tag);
      @(negedge clk);
      lk_req = 1'b1; lk_index = idx[7:0];
      @(negedge clk);
      lk_req = 1'b0;
      chk({tag, " valid"}, {31'd0, lk_valid}, 32'd1);
      chk(tag, {8'd0, lk_rgb}, {8'd0, expect_entry(idx)});
   endtask

   task automatic t_reset;
      chk("R1 valid low", {31'd0, lk_valid}, 32'd0);
      chk("R1 rdata zero", cpu_rdata, 32'd0);
      do_read(0, "R1 word0");
      do_read(127, "R1 word127");
      do_lookup(0, "R1 entry0");
      do_lookup(255, "R1 entry255");
   endtask

   task automatic t_raw_and_pair;
      do_write(5, 32'h8123_F456);
      do_read(5, "R2 raw keeps intensity");
      do_lookup(10, "R3 low half");
      do_lookup(11, "R3 high half");
      do_write(0, 32'h0001_001F);
      do_write(127, 32'h7C00_03E0);
      do_read(127, "R2 last word");
      do_lookup(0, "R4 red only");
      do_lookup(1, "R4 red lsb");
      do_lookup(254, "R4 green only");
      do_lookup(255, "R4 blue only");
   endtask

   task automatic t_expand;
      do_write(64, 32'h7FFF_4210);
      do_lookup(128, "R5 mid pattern");
      do_lookup(129, "R5 all ones");
      chk("R5 full scale", {8'd0, lk_rgb}, 32'h00F8F8F8);
   endtask

   task automatic t_intensity;
      logic [23:0] ref_rgb;
      do_write(9, 32'h1234_5678);
      do_lookup(18, "R6 baseline");
      ref_rgb = lk_rgb;
      do_write(9, 32'h9234_D678);
      do_lookup(18, "R6 low intensity set");
      chk("R6 low unchanged", {8'd0, lk_rgb}, {8'd0, ref_rgb});
      do_lookup(19, "R6 high intensity set");
   endtask

   task automatic t_latency;
      @(negedge clk);
      lk_req = 1'b1; lk_index = 8'd128;
      @(posedge clk); #1;
      chk("R7 valid after edge", {31'd0, lk_valid}, 32'd1);
      lk_req = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R7 valid drops", {31'd0, lk_valid}, 32'd0);
   endtask

   task automatic t_collide_lookup;
      logic [31:0] old_word;
      logic [23:0] old_rgb;
      old_word = shadow[20];
      old_rgb = widen(old_word[31:16]);
      @(negedge clk);
      cpu_we = 1'b1; cpu_waddr = 7'd20; cpu_wdata = 32'h2468_1357;
      lk_req = 1'b1; lk_index = 8'd41;
      @(negedge clk);
      cpu_we = 1'b0; lk_req = 1'b0;
      shadow[20] = 32'h2468_1357;
      chk("R8 old colour", {8'd0, lk_rgb}, {8'd0, old_rgb});
      do_lookup(41, "R8 new colour");
   endtask

   task automatic t_collide_read;
      logic [31:0] old_word;
      old_word = shadow[33];
      @(negedge clk);
      cpu_we = 1'b1; cpu_waddr = 7'd33; cpu_wdata = 32'hCAFE_0BAD;
      cpu_re = 1'b1; cpu_raddr = 7'd33;
      @(negedge clk);
      cpu_we = 1'b0; cpu_re = 1'b0;
      chk("R9 old word", cpu_rdata, old_word);
      shadow[33] = 32'hCAFE_0BAD;
      do_read(33, "R9 new word");
   endtask

   task automatic t_hold;
      logic [23:0] held;
      do_lookup(66, "R10 setup");
      held = lk_rgb;
      do_write(33, 32'h0000_0000);
      repeat (3) @(negedge clk);
      chk("R10 held colour", {8'd0, lk_rgb}, {8'd0, held});
      chk("R10 valid idle", {31'd0, lk_valid}, 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 128; i++) shadow[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_raw_and_pair();
      t_expand();
      t_intensity();
      t_latency();
      t_collide_lookup();
      t_collide_read();
      t_hold();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule